// File: doc/BRIEF.md
# Timeslot-Group TDM Switch with Dual-Bank Mapping

This block moves whole groups of consecutive timeslots between three TDM interfaces: a backplane port and two mezzanine ports. Each interface enters the switch already parallelised to one byte per clock. A frame holds `STREAMS*CHANS` timeslots. The frame pulse marks slot 0, and the slots after it follow in order. Slots are split into groups of `GRP` consecutive timeslots. For a full backplane, `GRP` is 32 (one E1 frame), `STREAMS` is 32 and `CHANS` is 128. The defaults are scaled down to 4 streams of 8 channels with 8-slot groups, which keeps the data memory small.

Each destination group on each interface reads one entry from a connection table. The entry names a source interface and a source group. Any group can go to any interface. A mezzanine port can also loop a group back onto itself, and one source group can feed several destinations. Every byte leaves the switch exactly two frames after it arrived, on every route, because the data memory is triple-buffered by frame.

The connection table has two banks. A CPU port writes only the bank that is not in use. A swap request takes effect at the next frame pulse, so the first slot of the new frame already uses the new mapping.

Top module: `tsg_switch`

## Requirements
- R1: A high `fp` marks slot 0 of a frame. Each later clock is the next slot. Slot s belongs to group s/GRP at offset s%GRP.
- R2: A byte received in slot s of frame n appears on a transmit port in slot s of frame n+2, one clock after that slot's input cycle, whatever the route.
- R3: A destination group with a valid entry {source interface, source group} carries, at each offset, the source interface's byte from the same offset of the source group. The same source may feed several destinations.
- R4: A mezzanine interface whose entry names itself as source loops its own received group back to its transmit port.
- R5: A transmit port outputs 0xFF when any of these holds: the entry is invalid, the entry's source interface code is 3, or the frame is earlier than the one begun by the third frame pulse after reset.
- R6: Interface codes are 0 for the backplane, 1 for mezzanine A and 2 for mezzanine B. A CPU write stores {valid, source interface, source group} for (destination interface, destination group) into the inactive bank only. A destination code of 3 is ignored.
- R7: `swap_req` sets `swap_pending`. At the next `fp` the active bank toggles, `swap_pending` clears, and the slot-0 output of that frame already uses the new bank. `active_bank` changes at no other time.
- R8: While a swap is pending, CPU writes and further swap requests have no effect.
- R9: After reset, `active_bank` and `swap_pending` are 0, every entry in both banks is invalid, and all transmit ports output 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one timeslot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp | input | 1 | Frame pulse, high during slot 0 |
| bp_rx | input | 8 | Backplane receive byte |
| ma_rx | input | 8 | Mezzanine A receive byte |
| mb_rx | input | 8 | Mezzanine B receive byte |
| bp_tx | output | 8 | Backplane transmit byte |
| ma_tx | output | 8 | Mezzanine A transmit byte |
| mb_tx | output | 8 | Mezzanine B transmit byte |
| cfg_we | input | 1 | Connection-table write strobe |
| cfg_dst_if | input | 2 | Destination interface code |
| cfg_dst_grp | input | GW | Destination group |
| cfg_valid | input | 1 | Entry valid flag |
| cfg_src_if | input | 2 | Source interface code |
| cfg_src_grp | input | GW | Source group |
| swap_req | input | 1 | Request a bank swap at the next frame |
| active_bank | output | 1 | Bank in use |
| swap_pending | output | 1 | Swap waiting for a frame pulse |

## Verification
A slot counter that is off by one makes every route carry a neighbouring byte. This shows at the first routed slot after the third frame pulse. A wrong frame-buffer rotation makes data arrive one or three frames late, which the per-frame signature in every byte exposes within one frame. A bank that swaps early, or a write that lands in the live bank, changes a destination group in mid-frame. The bench compares every byte of every port in every cycle, so it sees that change in the very slot it occurs.

// File: rtl/tsg_switch.sv
module tsg_switch #(
  parameter int STREAMS = 4,
  parameter int CHANS   = 8,
  parameter int GRP     = 8,
  localparam int NSLOT  = STREAMS * CHANS,
  localparam int NGRP   = NSLOT / GRP,
  localparam int GW     = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp,
  input  logic [7:0]    bp_rx,
  input  logic [7:0]    ma_rx,
  input  logic [7:0]    mb_rx,
  output logic [7:0]    bp_tx,
  output logic [7:0]    ma_tx,
  output logic [7:0]    mb_tx,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_dst_if,
  input  logic [GW-1:0] cfg_dst_grp,
  input  logic          cfg_valid,
  input  logic [1:0]    cfg_src_if,
  input  logic [GW-1:0] cfg_src_grp,
  input  logic          swap_req,
  output logic          active_bank,
  output logic          swap_pending
);
  localparam int SW = $clog2(NSLOT);
  localparam int OW = $clog2(GRP);
  localparam int EW = 3 + GW;
  localparam logic [7:0] IDLE = 8'hFF;

  logic [SW-1:0] slot_q, slot_c;
  logic [1:0]    wbuf_q, wbuf_c, rbuf_c, prime_q, prime_c;
  logic          act_q, pend_q, bank_c, primed;
  logic [GW-1:0] grp_c;
  logic [OW-1:0] off_c;

  function automatic logic [1:0] nxt3(input logic [1:0] b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction

  assign slot_c  = fp ? '0 : ((slot_q == SW'(NSLOT-1)) ? '0 : slot_q + 1'b1);
  assign wbuf_c  = fp ? nxt3(wbuf_q) : wbuf_q;
  assign rbuf_c  = nxt3(wbuf_c);
  assign prime_c = (fp && prime_q != 2'd3) ? prime_q + 2'd1 : prime_q;
  assign primed  = (prime_c == 2'd3);
  assign bank_c  = (fp && pend_q) ? ~act_q : act_q;
  assign grp_c   = GW'(slot_c >> OW);
  assign off_c   = slot_c[OW-1:0];

  assign active_bank  = act_q;
  assign swap_pending = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      wbuf_q  <= '0;
      prime_q <= '0;
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      slot_q  <= slot_c;
      wbuf_q  <= wbuf_c;
      prime_q <= prime_c;
      act_q   <= bank_c;
      pend_q  <= pend_q ? !fp : swap_req;
    end
  end

  logic [7:0] rx [3];
  assign rx[0] = bp_rx;
  assign rx[1] = ma_rx;
  assign rx[2] = mb_rx;

  logic [7:0] dmem [3][3][NSLOT];
  always_ff @(posedge clk) begin
    for (int i = 0; i < 3; i++) dmem[i][wbuf_c][slot_c] <= rx[i];
  end

  logic [EW-1:0] cm_q [2][3][NGRP];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int d = 0; d < 3; d++)
          for (int g = 0; g < NGRP; g++) cm_q[b][d][g] <= '0;
    end else if (cfg_we && !pend_q && cfg_dst_if != 2'd3) begin
      cm_q[~act_q][cfg_dst_if][cfg_dst_grp] <= {cfg_valid, cfg_src_if, cfg_src_grp};
    end
  end

  for (genvar d = 0; d < 3; d++) begin : g_dst
    logic          ev;
    logic [1:0]    esi, sel;
    logic [GW-1:0] esg;
    logic [7:0]    rd, q;
    assign {ev, esi, esg} = cm_q[bank_c][d][grp_c];
    assign sel = (esi == 2'd3) ? 2'd0 : esi;
    assign rd  = dmem[sel][rbuf_c][SW'({esg, off_c})];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= IDLE;
      else        q <= (primed && ev && esi != 2'd3) ? rd : IDLE;
    end
  end

  assign bp_tx = g_dst[0].q;
  assign ma_tx = g_dst[1].q;
  assign mb_tx = g_dst[2].q;

  a_r7_swap_only_on_fp: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> $past(fp && pend_q));
  a_r7_swap_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (fp && pend_q) |=> (!pend_q && act_q != $past(act_q)));
  a_r8_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !fp) |=> (pend_q && $stable(act_q)));
  a_r5_idle_unprimed: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> (bp_tx == IDLE && ma_tx == IDLE && mb_tx == IDLE));
  a_r1_buffers_apart: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> (wbuf_q != $past(wbuf_q) && slot_q == '0));
endmodule

// File: tb/tb_tsg_switch.sv
module tb_tsg_switch;
  localparam int NS = 32, G = 8, NG = 4;

  logic clk = 0, rst_n = 0, fp = 0;
  logic [7:0] bp_rx = 0, ma_rx = 0, mb_rx = 0, bp_tx, ma_tx, mb_tx;
  logic cfg_we = 0, cfg_valid = 0, swap_req = 0;
  logic [1:0] cfg_dst_if = 0, cfg_src_if = 0, cfg_dst_grp = 0, cfg_src_grp = 0;
  logic active_bank, swap_pending;

  tsg_switch dut (.clk(clk), .rst_n(rst_n), .fp(fp), .bp_rx(bp_rx), .ma_rx(ma_rx), .mb_rx(mb_rx),
    .bp_tx(bp_tx), .ma_tx(ma_tx), .mb_tx(mb_tx), .cfg_we(cfg_we), .cfg_dst_if(cfg_dst_if),
    .cfg_dst_grp(cfg_dst_grp), .cfg_valid(cfg_valid), .cfg_src_if(cfg_src_if),
    .cfg_src_grp(cfg_src_grp), .swap_req(swap_req), .active_bank(active_bank),
    .swap_pending(swap_pending));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, pos = 0, frame = -1, slot = 0, prime = 0;
  bit started = 0, done = 0, mact = 0, mpend = 0;
  logic [4:0] mb [2][3][NG];
  int qs[$]; logic [23:0] qe[$]; string qt0[$], qt1[$], qt2[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] gen(int i, int f, int s);
    return 8'(i * 64 + f * 37 + s * 3 + 1);
  endfunction

  task automatic chk(int got, int exp, string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (qs.size() > 0 && cyc > qs[0]) begin
      logic [23:0] e;
      string t0, t1, t2;
      void'(qs.pop_front());
      e = qe.pop_front(); t0 = qt0.pop_front(); t1 = qt1.pop_front(); t2 = qt2.pop_front();
      chk(bp_tx, e[7:0], {t0, " bp"});
      chk(ma_tx, e[15:8], {t1, " ma"});
      chk(mb_tx, e[23:16], {t2, " mb"});
    end
  end

  task automatic step();
    bit fpv, eff;
    logic [23:0] ex;
    string t[3];
    fpv = started && (pos % NS == 0);
    if (started) pos++;
    if (fpv) begin frame++; slot = 0; if (prime < 3) prime++; end else slot++;
    fp = fpv;
    bp_rx = gen(0, frame, slot); ma_rx = gen(1, frame, slot); mb_rx = gen(2, frame, slot);
    eff = (fpv && mpend) ? ~mact : mact;
    for (int d = 0; d < 3; d++) begin
      logic [4:0] e;
      e = mb[eff][d][(slot % NS) / G];
      if (prime < 3 || !e[4] || e[3:2] == 2'd3) begin
        ex[d*8 +: 8] = 8'hFF; t[d] = "R5";
      end else begin
        ex[d*8 +: 8] = gen(int'(e[3:2]), frame - 2, int'(e[1:0]) * G + slot % G);
        t[d] = (int'(e[3:2]) == d && d != 0) ? "R4" : "R1 R2 R3";
      end
    end
    qs.push_back(cyc); qe.push_back(ex); qt0.push_back(t[0]); qt1.push_back(t[1]); qt2.push_back(t[2]);
    if (cfg_we && !mpend && cfg_dst_if != 2'd3)
      mb[~mact][cfg_dst_if][cfg_dst_grp] = {cfg_valid, cfg_src_if, cfg_src_grp};
    if (mpend) begin
      if (fpv) begin mact = ~mact; mpend = 0; end
    end else if (swap_req) mpend = 1;
    @(negedge clk);
    cfg_we = 0; swap_req = 0;
    chk(active_bank, mact, "R7 active_bank");
    chk(swap_pending, mpend, "R8 swap_pending");
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cfg(int dst, int grp, bit v, int src, int sg);
    cfg_we = 1; cfg_dst_if = 2'(dst); cfg_dst_grp = 2'(grp);
    cfg_valid = v; cfg_src_if = 2'(src); cfg_src_grp = 2'(sg);
    step();
  endtask

  task automatic to_slot(int k);
    while (pos % NS != k) step();
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int d = 0; d < 3; d++)
        for (int g = 0; g < NG; g++) mb[b][d][g] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bp_tx, 8'hFF, "R9 bp idle"); chk(ma_tx, 8'hFF, "R9 ma idle");
    chk(mb_tx, 8'hFF, "R9 mb idle"); chk(active_bank, 0, "R9 bank");
    chk(swap_pending, 0, "R9 pending");
    run(5);
    started = 1;
    run(3 * NS);
    // R6: bank 1 is inactive, load routes, then swap in mid-frame
    cfg(0, 0, 1, 1, 1); cfg(0, 1, 1, 2, 3); cfg(0, 2, 1, 0, 2);
    cfg(1, 0, 1, 1, 2); cfg(1, 3, 1, 0, 0); cfg(2, 1, 1, 2, 1);
    cfg(2, 2, 1, 0, 0); cfg(2, 3, 1, 3, 0); cfg(3, 0, 1, 0, 0);
    swap_req = 1; step();
    run(3 * NS);
    // R6: write the inactive bank 0 while bank 1 carries traffic
    cfg(0, 3, 1, 2, 0); cfg(1, 1, 1, 1, 1);
    run(NS);
    // R8: writes and repeat requests during a pending swap are dropped
    to_slot(10);
    swap_req = 1; step();
    cfg(0, 0, 1, 2, 2);
    swap_req = 1; step();
    run(2 * NS);
    // R7: request in the last slot, swap at the following frame pulse
    to_slot(NS - 1);
    swap_req = 1; step();
    run(NS);
    // R7: request in the frame-pulse slot waits for the next frame
    to_slot(0);
    swap_req = 1; step();
    run(2 * NS + 3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule